// File: doc/BRIEF.md
# Serial Key Code Emitter

This block waits in an idle state until a trigger input is seen high on a rising clock edge. It then shifts out a fixed four-bit identification code on a single serial output, one bit per clock cycle, and goes back to idle. A busy flag is high for the whole four-cycle window, so a downstream receiver can frame the bits without any other signal.

The block is a Moore machine. Both outputs are decoded from the state register alone, so they move only on rising clock edges and never follow the trigger within a cycle. The code is fixed when the design is built. The first bit sent is the most significant bit of the code constant `4'b1011`, so the bits leave as 1, 0, 1, 1. While an emission is in progress the trigger is ignored. If the trigger is still high when the block is back in idle, the next emission starts.

Top module: `keycode_emitter`

## Requirements
- R1: While idle with `trig` low, the block stays idle, and `key_bit` and `busy` are both 0.
- R2: `trig` sampled high on a rising edge while idle starts an emission. `busy` and the first code bit appear right after that edge.
- R3: The four bits on `key_bit` during an emission are 1, 0, 1, 1 in that order. This is the code constant `4'b1011`, sent most significant bit first.
- R4: After the fourth bit the block returns to idle whatever `trig` is. `busy` and `key_bit` are 0 in the following cycle.
- R5: `trig` has no effect during the four emission cycles. Toggling it there leaves the bit sequence and its length unchanged.
- R6: With `trig` held high, emissions repeat. Each four-cycle burst is followed by exactly one idle cycle with `busy` and `key_bit` at 0.
- R7: A synchronous active-high `rst` forces idle. After a rising edge with `rst` high, `busy` and `key_bit` are 0, even in the middle of an emission.
- R8: `busy` is high in exactly the four emission cycles of each burst and never for a longer run.
- R9: The outputs change only at rising clock edges. A change of `trig` between edges leaves `key_bit` and `busy` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to idle |
| trig | input | 1 | Starts an emission when seen high while idle |
| key_bit | output | 1 | Serial code bit, 0 when idle |
| busy | output | 1 | High during the four emission cycles |

## Verification
Two functions can fall on the same edge. The first is the end of a burst together with a trigger that is still high. The second is a reset in the middle of a burst against the step to the next code bit. The bench holds `trig` high across several bursts and asserts `rst` on the second bit of a burst. It compares `key_bit` and `busy` every cycle against a queue-based model. That model inserts the single idle cycle between bursts and empties its queue on reset. Toggling `trig` between edges during a burst then shows that the outputs hold until the next edge.

// File: rtl/keycode_pkg.sv
`timescale 1ns/1ps
package keycode_pkg;
    // Length of the emitted code and the code itself, sent MSB first.
    localparam int                   CODE_LEN = 4;
    localparam logic [CODE_LEN-1:0]  KEY_CODE = 4'b1011;

    // State encoding: 0 is idle, k+1 is emission of bit k.
    localparam int STW = $clog2(CODE_LEN + 1);
    typedef logic [STW-1:0] kce_state_t;

    localparam kce_state_t ST_IDLE  = '0;
    localparam kce_state_t ST_FIRST = kce_state_t'(1);
    localparam kce_state_t ST_LAST  = kce_state_t'(CODE_LEN);

    typedef struct packed {
        logic bit_o;
        logic busy;
    } kce_out_t;

    // Code bit sent in emission slot idx.
    function automatic logic slot_bit(input int idx);
        return KEY_CODE[CODE_LEN-1-idx];
    endfunction
endpackage

// File: rtl/kce_next.sv
`timescale 1ns/1ps
module kce_next
    import keycode_pkg::*;
(
    input  kce_state_t cur,
    input  logic       start,
    output kce_state_t nxt
);
    always_comb begin
        if (cur == ST_IDLE) begin
            nxt = start ? ST_FIRST : ST_IDLE;
        end else if (cur < ST_LAST) begin
            nxt = cur + kce_state_t'(1);
        end else begin
            // last slot and any unused code fall back to idle
            nxt = ST_IDLE;
        end
    end
endmodule

// File: rtl/kce_decode.sv
`timescale 1ns/1ps
module kce_decode
    import keycode_pkg::*;
(
    input  kce_state_t cur,
    output kce_out_t   outs
);
    logic [CODE_LEN-1:0] hit;
    logic [CODE_LEN-1:0] onebits;

    for (genvar k = 0; k < CODE_LEN; k++) begin : g_slot
        assign hit[k]     = (cur == kce_state_t'(k + 1));
        assign onebits[k] = hit[k] & slot_bit(k);
    end

    always_comb begin
        outs.busy  = |hit;
        outs.bit_o = |onebits;
    end
endmodule

// File: rtl/keycode_emitter.sv
`timescale 1ns/1ps
module keycode_emitter
    import keycode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic key_bit,
    output logic busy
);
    kce_state_t state_q;
    kce_state_t state_d;
    kce_out_t   dec;

    kce_next u_next (
        .cur   (state_q),
        .start (trig),
        .nxt   (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    kce_decode u_dec (
        .cur  (state_q),
        .outs (dec)
    );

    assign key_bit = dec.bit_o;
    assign busy    = dec.busy;
endmodule

// File: rtl/kce_checker.sv
`timescale 1ns/1ps
module kce_checker (
    input logic clk,
    input logic rst,
    input logic act_i,
    input logic ser_i,
    input logic busy_i
);
    // cycles already spent busy in the current run
    logic [2:0] run_q;
    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (busy_i) run_q <= run_q + 3'd1;
        else             run_q <= '0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && !act_i) |=> (!busy_i && !ser_i));
    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_i |-> !ser_i);
    // R2
    start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && act_i) |=> (busy_i && ser_i));
    // R3
    zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && run_q == 3'd1) |-> !ser_i);
    // R3
    one_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && run_q != 3'd1) |-> ser_i);
    // R8
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (run_q < 3'd4));
    // R4
    end_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && run_q == 3'd3) |=> !busy_i);
    // R7
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy_i && !ser_i));
endmodule

bind keycode_emitter kce_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .act_i  (trig),
    .ser_i  (key_bit),
    .busy_i (busy)
);

// File: tb/sim_keycode_emitter.sv
`timescale 1ns/100ps
module sim_keycode_emitter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic key_bit;
    logic busy;

    int checks = 0;
    int fails = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    keycode_emitter u0 (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .key_bit (key_bit),
        .busy    (busy)
    );

    // Behavioural reference: queue of bits still to send.
    bit pend[$];
    always @(posedge clk) begin
        if (rst)                  pend.delete();
        else if (pend.size() > 0) void'(pend.pop_front());
        else if (trig)            pend = '{1'b1, 1'b0, 1'b1, 1'b1};
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    task automatic compare(input string req);
        logic eb, ek;
        eb = (pend.size() > 0);
        ek = eb ? pend[0] : 1'b0;
        checks++;
        if (busy !== eb || key_bit !== ek) begin
            fails++;
            $display("FAIL %s: busy=%b key_bit=%b expected busy=%b key_bit=%b",
                     req, busy, key_bit, eb, ek);
        end
    endtask

    // Compare at the falling edge, then drive inputs for the next edge.
    task automatic cyc(input logic a, input logic r, input string req);
        @(negedge clk);
        compare(req);
        trig = a;
        rst  = r;
    endtask

    // R9: outputs hold while trig moves between edges.
    task automatic midcheck();
        logic kb, bz, keep;
        @(posedge clk);
        #0.5;
        kb = key_bit; bz = busy; keep = trig;
        trig = ~keep;
        #0.5;
        checks++;
        if (key_bit !== kb || busy !== bz) begin
            fails++;
            $display("FAIL R9: busy=%b key_bit=%b expected busy=%b key_bit=%b",
                     busy, key_bit, bz, kb);
        end
        trig = keep;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        report();
    end

    initial begin
        // R7 reset state
        repeat (3) cyc(1'b0, 1'b1, "R7");
        // R1 idle with trig low
        repeat (5) cyc(1'b0, 1'b0, "R1");
        // R2 R3 R8 single trigger pulse, R4 return to idle
        cyc(1'b1, 1'b0, "R2");
        repeat (4) cyc(1'b0, 1'b0, "R3");
        repeat (4) cyc(1'b0, 1'b0, "R4");
        // R5 trigger toggled during the burst is ignored
        cyc(1'b1, 1'b0, "R2");
        cyc(1'b0, 1'b0, "R5");
        cyc(1'b1, 1'b0, "R5");
        cyc(1'b1, 1'b0, "R5");
        cyc(1'b0, 1'b0, "R5");
        repeat (4) cyc(1'b0, 1'b0, "R4");
        // R6 trigger held high repeats with one idle gap
        repeat (16) cyc(1'b1, 1'b0, "R6");
        repeat (6) cyc(1'b0, 1'b0, "R8");
        // R7 reset in the middle of a burst
        cyc(1'b1, 1'b0, "R2");
        cyc(1'b0, 1'b0, "R3");
        cyc(1'b0, 1'b1, "R7");
        repeat (4) cyc(1'b0, 1'b0, "R7");
        // R9 mid-cycle trigger changes during a burst
        cyc(1'b1, 1'b0, "R2");
        cyc(1'b0, 1'b0, "R3");
        midcheck();
        cyc(1'b0, 1'b0, "R9");
        midcheck();
        cyc(1'b0, 1'b0, "R9");
        repeat (4) cyc(1'b0, 1'b0, "R4");
        // R9 mid-cycle change while idle must not start output early
        midcheck();
        cyc(1'b0, 1'b0, "R1");
        report();
    end
endmodule